// File: doc/BRIEF.md
# Dual Interval Timer Register Window

This block places two independent down-counting interval timers behind one 4 KB register window on a word-addressed bus. Each timer advances on its own tick-enable input, so the integrating chip sets each timer's reference rate by how often it pulses that input. Software programs a timer by writing its reload value and its mode byte, then waits for its interrupt. The two timer interrupts leave the block on one combined line.

Each timer can free-run, reload periodically, or stop after one pass. It counts 16 or 32 bits wide and can divide its tick by 1, 16 or 256. The window also holds eight read-only identification words and two integration-test stub words that read as zero. A one-cycle error strobe marks every access that hits no mapped word. Read data is registered and appears the cycle after the read is presented.

Top module: `dual_timer_wrap`

## Requirements
- R1: Word offsets 0x000 to 0x01F address the first timer; within a timer the byte offsets are 0x00 reload-now, 0x04 current count (read-only), 0x08 mode byte, 0x0C interrupt clear (write-only, reads zero), 0x10 raw interrupt, 0x14 masked interrupt, 0x18 reload-deferred. Both reload offsets read back the reload value.
- R2: Offsets 0x020 to 0x03F reach the second timer with 0x20 removed, and an access there leaves the first timer untouched.
- R3: Reads of 0xFE0, 0xFE4, …, 0xFFC return 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order, and writes there change nothing.
- R4: Reads of 0xF00 and 0xF04 return zero, and writes there change nothing.
- R5: Any other offset, including 0x1C and 0x3C, reads zero and ignores writes. The error output is high for exactly the one cycle after such an access and low after mapped accesses.
- R6: The combined interrupt is high whenever either timer's masked interrupt is high.
- R7: Mode byte bit 7 enables counting. While enabled, each divided tick lowers a non-zero count by one. The step from 1 to 0 sets the raw interrupt. In periodic mode (bit 6 set, bit 0 clear), the next divided tick at zero loads the reload value.
- R8: In free-running mode (bits 6 and 0 clear), a divided tick at zero loads 0xFFFF when bit 1 is clear (16-bit width) or 0xFFFFFFFF when bit 1 is set.
- R9: In one-shot mode (bit 0 set), the count stays at zero after it reaches zero, and no further interrupt is raised.
- R10: Mode bits 3:2 choose the tick divider: 01 gives one step per 16 ticks, 10 gives one step per 256 ticks, and other values give one step per tick. Writing the mode byte restarts the divider.
- R11: A reload-now write sets both the reload value and the count. A reload-deferred write sets only the reload value, and the count keeps running.
- R12: A write to the interrupt clear offset clears the raw interrupt, unless the count reaches zero in that same cycle, in which case the raw interrupt stays set.
- R13: After reset each mode byte is 0x20 (interrupt mask bit 5 set, stopped) and the count, reload and raw interrupt are zero. The masked interrupt is the raw interrupt ANDed with bit 5. Writes to the count offset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en0 | input | 1 | Tick enable, first timer |
| tick_en1 | input | 1 | Tick enable, second timer |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address (byte offset bits 11:2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | One-cycle strobe after an unmapped access |
| irq | output | 1 | Combined timer interrupt |

## Verification
Two events can fall in the same cycle: software clears the interrupt while the counter steps from one to zero. The bench loads a count of one, then presents the clear write and a tick on the same clock edge. It passes if the raw interrupt reads back as set and the combined interrupt stays high, so the new expiry is not lost. A control run with the clear and no tick must read back zero.

// File: rtl/dtw_pkg.sv
package dtw_pkg;
    localparam int DW      = 32;
    localparam int AW      = 10;
    localparam int N_TMR   = 2;
    localparam int TMR_WDS = 8;
    localparam int WORD_W  = $clog2(TMR_WDS);

    localparam logic [WORD_W-1:0] W_LOAD  = 3'd0;
    localparam logic [WORD_W-1:0] W_COUNT = 3'd1;
    localparam logic [WORD_W-1:0] W_CTRL  = 3'd2;
    localparam logic [WORD_W-1:0] W_ICLR  = 3'd3;
    localparam logic [WORD_W-1:0] W_RAW   = 3'd4;
    localparam logic [WORD_W-1:0] W_MSK   = 3'd5;
    localparam logic [WORD_W-1:0] W_BGLD  = 3'd6;

    localparam int B_ONE  = 0;
    localparam int B_SIZE = 1;
    localparam int B_PRE  = 2;
    localparam int B_IE   = 5;
    localparam int B_PER  = 6;
    localparam int B_EN   = 7;
    localparam logic [7:0] CTRL_RST = 8'h20;

    localparam logic [AW-1:0] TST_BASE = 10'h3C0;
    localparam logic [AW-1:0] ID_BASE  = 10'h3F8;

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        case (idx)
            3'd0: id_byte = 8'h04;
            3'd1: id_byte = 8'h18;
            3'd2: id_byte = 8'h14;
            3'd3: id_byte = 8'h00;
            3'd4: id_byte = 8'h0D;
            3'd5: id_byte = 8'hF0;
            3'd6: id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction
endpackage

// File: rtl/dtw_prescale.sv
module dtw_prescale #(
    parameter int DIV_A_SH = 4,
    parameter int DIV_B_SH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       clr,
    input  logic [1:0] sel,
    output logic       fire
);
    localparam int PW = DIV_B_SH;
    localparam logic [PW-1:0] MASK_A = PW'((1 << DIV_A_SH) - 1);
    localparam logic [PW-1:0] MASK_B = PW'((1 << DIV_B_SH) - 1);

    logic [PW-1:0] cnt_d, cnt_q, mask;

    always_comb begin
        case (sel)
            2'd1:    mask = MASK_A;
            2'd2:    mask = MASK_B;
            default: mask = '0;
        endcase
        fire  = tick_en && ((cnt_q & mask) == mask);
        cnt_d = cnt_q;
        if (clr)          cnt_d = '0;
        else if (tick_en) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    a_r10_no_fire_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |-> !fire);
endmodule

// File: rtl/dtw_timer.sv
module dtw_timer
    import dtw_pkg::*;
#(
    parameter int SHORT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] word,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              irq
);
    localparam logic [DW-1:0] SHORT_MASK = {{(DW-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};

    typedef struct packed {
        logic [DW-1:0] load;
        logic [DW-1:0] count;
        logic [7:0]    ctrl;
        logic          raw;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic [DW-1:0] msk, cur;
    logic fire, hit_zero, ctrl_wr;

    assign ctrl_wr = wr_en && (word == W_CTRL);

    dtw_prescale u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .clr     (ctrl_wr),
        .sel     (st_q.ctrl[B_PRE+1:B_PRE]),
        .fire    (fire)
    );

    always_comb begin
        st_d     = st_q;
        hit_zero = 1'b0;
        msk      = st_q.ctrl[B_SIZE] ? '1 : SHORT_MASK;
        cur      = st_q.count & msk;
        if (fire && st_q.ctrl[B_EN]) begin
            if (cur == '0) begin
                if (st_q.ctrl[B_ONE])      st_d.count = cur;
                else if (st_q.ctrl[B_PER]) st_d.count = st_q.load & msk;
                else                       st_d.count = msk;
            end else begin
                st_d.count = cur - 1'b1;
                hit_zero   = (cur == DW'(1));
            end
        end
        if (hit_zero) st_d.raw = 1'b1;
        if (wr_en) begin
            case (word)
                W_LOAD: begin
                    st_d.load  = wdata;
                    st_d.count = wdata & msk;
                end
                W_CTRL: st_d.ctrl = wdata[7:0];
                W_ICLR: st_d.raw  = hit_zero;
                W_BGLD: st_d.load = wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (word)
            W_LOAD, W_BGLD: rdata = st_q.load;
            W_COUNT:        rdata = cur;
            W_CTRL:         rdata = DW'(st_q.ctrl);
            W_RAW:          rdata = DW'(st_q.raw);
            W_MSK:          rdata = DW'(st_q.raw & st_q.ctrl[B_IE]);
            default:        rdata = '0;
        endcase
    end

    assign irq = st_q.raw & st_q.ctrl[B_IE];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.load  <= '0;
            st_q.count <= '0;
            st_q.ctrl  <= CTRL_RST;
            st_q.raw   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: one step down per divided tick
    a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && st_q.ctrl[B_EN] && cur > DW'(1) && !wr_en)
        |=> st_q.count == $past(cur) - 1'b1);
    // R9: one-shot holds at zero
    a_r9_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && st_q.ctrl[B_EN] && st_q.ctrl[B_ONE] && cur == '0 && !wr_en)
        |=> st_q.count == '0 && $stable(st_q.raw));
    // R12: expiry wins over a clear in the same cycle
    a_r12_expiry_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && st_q.ctrl[B_EN] && cur == DW'(1)) |=> st_q.raw);
    // R13: count offset writes ignored when no tick
    a_r13_count_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word == W_COUNT && !fire) |=> $stable(st_q.count));
endmodule

// File: rtl/dtw_decode.sv
module dtw_decode
    import dtw_pkg::*;
(
    input  logic [AW-1:0]     addr,
    output logic              tmr_hit,
    output logic              tmr_idx,
    output logic [WORD_W-1:0] word,
    output logic              id_hit,
    output logic [2:0]        id_idx,
    output logic              tst_hit,
    output logic              bad
);
    localparam int TMR_TOP = $clog2(N_TMR * TMR_WDS);

    always_comb begin
        word    = addr[WORD_W-1:0];
        tmr_idx = addr[WORD_W];
        tmr_hit = (addr[AW-1:TMR_TOP] == '0) && (word != 3'd7);
        id_idx  = addr[2:0];
        id_hit  = (addr[AW-1:3] == ID_BASE[AW-1:3]);
        tst_hit = (addr == TST_BASE) || (addr == TST_BASE + 1'b1);
        bad     = !(tmr_hit || id_hit || tst_hit);
    end
endmodule

// File: rtl/dual_timer_wrap.sv
module dual_timer_wrap
    import dtw_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en0,
    input  logic          tick_en1,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [9:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          bus_err,
    output logic          irq
);
    typedef struct packed {
        logic [DW-1:0] rdata;
        logic          err;
    } bus_st_t;

    bus_st_t b_d, b_q;
    logic tmr_hit, tmr_idx, id_hit, tst_hit, bad;
    logic [WORD_W-1:0] word;
    logic [2:0] id_idx;
    logic [N_TMR-1:0] t_tick, t_irq;
    logic [DW-1:0] t_rdata [N_TMR];

    assign t_tick = {tick_en1, tick_en0};

    dtw_decode u_dec (
        .addr    (bus_addr),
        .tmr_hit (tmr_hit),
        .tmr_idx (tmr_idx),
        .word    (word),
        .id_hit  (id_hit),
        .id_idx  (id_idx),
        .tst_hit (tst_hit),
        .bad     (bad)
    );

    for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
        logic wr_t;
        assign wr_t = bus_sel && bus_wr && tmr_hit && (tmr_idx == 1'(t));
        dtw_timer u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_en (t_tick[t]),
            .wr_en   (wr_t),
            .word    (word),
            .wdata   (bus_wdata),
            .rdata   (t_rdata[t]),
            .irq     (t_irq[t])
        );
    end

    always_comb begin
        b_d     = b_q;
        b_d.err = bus_sel && bad;
        if (bus_sel && !bus_wr) begin
            if (tmr_hit)     b_d.rdata = t_rdata[tmr_idx];
            else if (id_hit) b_d.rdata = DW'(id_byte(id_idx));
            else             b_d.rdata = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign bus_rdata = b_q.rdata;
    assign bus_err   = b_q.err;
    assign irq       = |t_irq;

    // R5: error only follows an access
    a_r5_err_after_sel: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_sel));
    // R3: first identification word
    a_r3_first_id: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == ID_BASE) |=> bus_rdata == 32'h04);
    // R4: test control word reads zero
    a_r4_test_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == TST_BASE) |=> bus_rdata == '0 && !bus_err);
endmodule

// File: tb/sim_dual_timer_wrap.sv
module sim_dual_timer_wrap;
    logic clk = 1'b0, rst_n = 1'b0;
    logic tick_en0 = 1'b0, tick_en1 = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [9:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic bus_err, irq;
    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [31:0] rv;
    logic er;

    always #2 clk = ~clk;

    dual_timer_wrap u0 (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: act hung exp done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act %h exp %h", req, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [11:0] off, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = w; bus_addr = off[11:2]; bus_wdata = d;
        @(negedge clk);
        rv = bus_rdata; er = bus_err;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] off); acc(1'b0, off, '0); endtask
    task automatic wr(input logic [11:0] off, input logic [31:0] d); acc(1'b1, off, d); endtask

    task automatic tick0(input int n);
        for (int i = 0; i < n; i++) begin tick_en0 = 1'b1; @(negedge clk); end
        tick_en0 = 1'b0;
    endtask

    task automatic t_reset;
        rd(12'h008); check("R13 ctrl A reset", rv, 32'h20);
        rd(12'h028); check("R13 ctrl B reset", rv, 32'h20);
        rd(12'h004); check("R13 count reset", rv, 0);
        check("R13 irq reset", {31'b0, irq}, 0);
    endtask

    task automatic t_decode;
        wr(12'h000, 5);  rd(12'h004); check("R1 count A", rv, 5);
        check("R1 no err", {31'b0, er}, 0);
        wr(12'h020, 9);  rd(12'h024); check("R2 count B", rv, 9);
        rd(12'h000); check("R2 A untouched", rv, 5);
        rd(12'h018); check("R1 reload readback", rv, 5);
        wr(12'h004, 77); rd(12'h004); check("R13 count write ignored", rv, 5);
        rd(12'h00C); check("R1 clear reads zero", rv, 0);
    endtask

    task automatic t_id;
        logic [7:0] exp_id [8] = '{8'h04, 8'h18, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        wr(12'hFE0, 32'hFF);
        for (int i = 0; i < 8; i++) begin
            rd(12'hFE0 + 12'(4 * i));
            check("R3 id byte", rv, {24'b0, exp_id[i]});
            check("R3 id no err", {31'b0, er}, 0);
        end
    endtask

    task automatic t_test;
        wr(12'hF00, 32'hFFFF_FFFF);
        rd(12'hF00); check("R4 test ctrl", rv, 0);
        wr(12'hF04, 32'h1);
        rd(12'hF04); check("R4 test out", rv, 0);
        check("R4 no err", {31'b0, er}, 0);
        rd(12'h004); check("R4 timer unchanged", rv, 5);
    endtask

    task automatic t_unmapped;
        rd(12'h000); rd(12'h100);
        check("R5 unmapped reads zero", rv, 0);
        check("R5 err pulse", {31'b0, er}, 1);
        @(negedge clk); check("R5 err one cycle", {31'b0, bus_err}, 0);
        wr(12'h01C, 32'h1234); check("R5 err word 7", {31'b0, er}, 1);
        rd(12'h01C); check("R5 word 7 zero", rv, 0);
        wr(12'h03C, 32'h1234); check("R5 err word 0x3C", {31'b0, er}, 1);
        rd(12'h004); check("R5 no side effect", rv, 5);
    endtask

    task automatic t_periodic;
        wr(12'h008, 32'hE2); wr(12'h000, 3);
        tick0(2); rd(12'h004); check("R7 count 1", rv, 1);
        check("R7 no irq yet", {31'b0, irq}, 0);
        tick0(1); rd(12'h004); check("R7 count 0", rv, 0);
        check("R6 irq from A", {31'b0, irq}, 1);
        tick0(1); rd(12'h004); check("R7 periodic reload", rv, 3);
        wr(12'h00C, 0); rd(12'h010); check("R12 clear raw", rv, 0);
        check("R6 irq low", {31'b0, irq}, 0);
    endtask

    task automatic t_mask;
        wr(12'h008, 32'hC2); wr(12'h000, 1); tick0(1);
        rd(12'h010); check("R13 raw set", rv, 1);
        rd(12'h014); check("R13 masked zero", rv, 0);
        check("R6 masked no irq", {31'b0, irq}, 0);
        wr(12'h028, 32'hE2); wr(12'h020, 1);
        tick_en1 = 1'b1; @(negedge clk); tick_en1 = 1'b0;
        check("R6 irq from B", {31'b0, irq}, 1);
        rd(12'h034); check("R6 B masked", rv, 1);
        wr(12'h02C, 0); wr(12'h00C, 0); wr(12'h028, 32'h20);
        check("R6 both clear", {31'b0, irq}, 0);
    endtask

    task automatic t_free;
        wr(12'h008, 32'hA0); wr(12'h000, 2);
        tick0(2); rd(12'h010); check("R8 raw at zero", rv, 1);
        tick0(1); rd(12'h004); check("R8 wrap 16", rv, 32'hFFFF);
        wr(12'h008, 32'hA2); wr(12'h000, 1);
        tick0(2); rd(12'h004); check("R8 wrap 32", rv, 32'hFFFF_FFFF);
        wr(12'h00C, 0);
    endtask

    task automatic t_oneshot;
        wr(12'h008, 32'hA3); wr(12'h000, 2);
        tick0(2); check("R9 irq", {31'b0, irq}, 1);
        wr(12'h00C, 0);
        tick0(3); rd(12'h004); check("R9 stays zero", rv, 0);
        check("R9 no new irq", {31'b0, irq}, 0);
    endtask

    task automatic t_prescale;
        wr(12'h008, 32'hE6); wr(12'h000, 10);
        tick0(15); rd(12'h004); check("R10 div16 hold", rv, 10);
        tick0(1);  rd(12'h004); check("R10 div16 step", rv, 9);
        wr(12'h008, 32'hEA); wr(12'h000, 10);
        tick0(255); rd(12'h004); check("R10 div256 hold", rv, 10);
        tick0(1);   rd(12'h004); check("R10 div256 step", rv, 9);
        wr(12'h008, 32'hEE); wr(12'h000, 10);
        tick0(1); rd(12'h004); check("R10 code 3 no divide", rv, 9);
    endtask

    task automatic t_bgload;
        wr(12'h008, 32'hE2); wr(12'h000, 4);
        tick0(1); wr(12'h018, 2);
        rd(12'h004); check("R11 bg keeps count", rv, 3);
        tick0(3); tick0(1); rd(12'h004); check("R11 bg reload used", rv, 2);
        wr(12'h00C, 0);
    endtask

    task automatic t_collide;
        wr(12'h000, 1);
        tick_en0 = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 10'h003;
        @(negedge clk);
        tick_en0 = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        check("R12 expiry wins irq", {31'b0, irq}, 1);
        rd(12'h010); check("R12 expiry wins raw", rv, 1);
        wr(12'h00C, 0); rd(12'h010); check("R12 plain clear", rv, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset; t_decode; t_id; t_test; t_unmapped; t_periodic;
        t_mask; t_free; t_oneshot; t_prescale; t_bgload; t_collide;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule